// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block couples two byte-wide ports, A and B, through two independent storage stages, one per direction. The A-to-B stage captures from port A and presents its stored value on port B; the B-to-A stage captures from port B and presents its stored value on port A. Each direction has its own three active-low controls: a chip enable, a latch enable and an output enable. The chip enable gates both the capture and the output driver. The output enable has no effect while the chip enable is high.

The core replaces tristate pins with separate input buses, output buses and driver-enable flags, so that it fits an on-chip design where the pad logic sits elsewhere. Storage is clocked by the system clock. While a stage is open, it reloads on every edge. Once its latch enable rises, it keeps the last value it sampled. The block also raises a flag whenever both directions drive at the same time. That case is reported but not prevented.

Top module: `bxc_top`

## Requirements
- R1: Synchronous reset clears both stored values to 0x00 and holds both driver flags and the clash flag low while reset is high.
- R2: While ce_ab_n and le_ab_n are both 0 (and port A is not being driven), each clock edge loads a_in into the A-to-B stage. b_out shows the loaded value right after that edge.
- R3: When le_ab_n is 1, the A-to-B stage keeps its value across clock edges. This holds in particular after a rising le_ab_n, where the kept value is the last one sampled.
- R4: When ce_ab_n is 1, the A-to-B stage keeps its value whatever le_ab_n is, and b_drv is 0 whatever oe_ab_n is.
- R5: b_drv is 1 exactly when ce_ab_n and oe_ab_n are both 0 outside reset. The flag responds in the same cycle as the controls, with no register in between.
- R6: The B-to-A direction obeys R2 to R5 with ce_ba_n, le_ba_n and oe_ba_n. It loads from b_in, presents on a_out and drives a_drv.
- R7: clash is 1 exactly when a_drv and b_drv are both 1 in the same cycle. The core keeps both drivers on in that case.
- R8: A stage ignores its data input while the port that input comes from is being driven by the block. The A-to-B stage does not load while a_drv is 1, and the B-to-A stage does not load while b_drv is 1.
- R9: b_out and a_out always present the stored values, never the live inputs. Changing a_in while the A-to-B stage holds leaves b_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Data sampled from port A |
| b_in | input | WIDTH | Data sampled from port B |
| ce_ab_n | input | 1 | A-to-B chip enable, active low |
| le_ab_n | input | 1 | A-to-B latch enable, active low |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| ce_ba_n | input | 1 | B-to-A chip enable, active low |
| le_ba_n | input | 1 | B-to-A latch enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_out | output | WIDTH | Value to place on port A (B-to-A stage) |
| a_drv | output | 1 | Port A driver on |
| b_out | output | WIDTH | Value to place on port B (A-to-B stage) |
| b_drv | output | 1 | Port B driver on |
| clash | output | 1 | Both ports driven in the same cycle |

## Verification
Captured data has a latency of one edge. A value applied with the stage open appears on the output port right after the next rising clock edge. Driver flags and the clash flag are combinational in the present controls. The bench changes inputs at the falling edge, lets one rising edge pass, and compares every output a short delay later. In that sample, the stored values reflect the edge just taken and the flags reflect the controls still applied. A reference model in the bench builds each expected item from the same inputs under these timing rules and queues it. A monitor pops the item and compares it at that sample point.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
   // Active-low control triple for one transfer direction
   typedef struct packed {
      logic ce_n;
      logic le_n;
      logic oe_n;
   } dir_ctl_t;

   localparam int NUM_DIRS = 2;
   localparam int DIR_AB   = 0;
   localparam int DIR_BA   = 1;

   function automatic int peer_dir(input int d);
      return (d == DIR_AB) ? DIR_BA : DIR_AB;
   endfunction
endpackage

// File: rtl/bxc_lane.sv
module bxc_lane
   import bxc_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter logic [WIDTH-1:0] CLEAR_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  dir_ctl_t         ctl,
   input  logic [WIDTH-1:0] din,
   input  logic             src_busy,
   output logic [WIDTH-1:0] held,
   output logic             drv_on
);
   logic             open_now;
   logic             load_now;
   logic [WIDTH-1:0] store_q;

   // open: chip enable and latch enable both asserted
   assign open_now = ~ctl.ce_n & ~ctl.le_n;
   // source port driven by this block: keep own output out of storage
   assign load_now = open_now & ~src_busy;

   always_ff @(posedge clk) begin
      if (rst)
         store_q <= CLEAR_VAL;
      else if (load_now)
         store_q <= din;
   end

   assign held   = store_q;
   assign drv_on = ~rst & ~ctl.ce_n & ~ctl.oe_n;
endmodule

// File: rtl/bxc_clash.sv
module bxc_clash #(
   parameter int N = 2
) (
   input  logic [N-1:0] drv,
   output logic         clash
);
   assign clash = ($countones(drv) > 1);
endmodule

// File: rtl/bxc_top.sv
module bxc_top
   import bxc_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             ce_ab_n,
   input  logic             le_ab_n,
   input  logic             oe_ab_n,
   input  logic             ce_ba_n,
   input  logic             le_ba_n,
   input  logic             oe_ba_n,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drv,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drv,
   output logic             clash
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bxc_top: WIDTH must be at least 1");
      end
   endgenerate

   dir_ctl_t            ctl  [NUM_DIRS];
   logic [WIDTH-1:0]    din  [NUM_DIRS];
   logic [WIDTH-1:0]    held [NUM_DIRS];
   logic [NUM_DIRS-1:0] drv;

   assign ctl[DIR_AB] = '{ce_n: ce_ab_n, le_n: le_ab_n, oe_n: oe_ab_n};
   assign ctl[DIR_BA] = '{ce_n: ce_ba_n, le_n: le_ba_n, oe_n: oe_ba_n};
   assign din[DIR_AB] = a_in;
   assign din[DIR_BA] = b_in;

   generate
      for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
         localparam int PEER = peer_dir(d);
         bxc_lane #(.WIDTH(WIDTH)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl[d]),
            .din     (din[d]),
            .src_busy(drv[PEER]),
            .held    (held[d]),
            .drv_on  (drv[d])
         );
      end
   endgenerate

   bxc_clash #(.N(NUM_DIRS)) u_clash (
      .drv  (drv),
      .clash(clash)
   );

   assign b_out = held[DIR_AB];
   assign b_drv = drv[DIR_AB];
   assign a_out = held[DIR_BA];
   assign a_drv = drv[DIR_BA];
endmodule

// File: rtl/bxc_top_chk.sv
module bxc_top_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic             ce_ab_n,
   input logic             le_ab_n,
   input logic             oe_ab_n,
   input logic             ce_ba_n,
   input logic             le_ba_n,
   input logic             oe_ba_n,
   input logic [WIDTH-1:0] a_out,
   input logic             a_drv,
   input logic [WIDTH-1:0] b_out,
   input logic             b_drv,
   input logic             clash
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (a_out == '0 && b_out == '0));
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |-> (!a_drv && !b_drv && !clash));
   // R2
   ab_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (!ce_ab_n && !le_ab_n && !a_drv) |=> (b_out == $past(a_in)));
   // R3
   ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
      le_ab_n |=> $stable(b_out));
   // R4
   ab_chip_off_chk: assert property (@(posedge clk) disable iff (rst)
      ce_ab_n |-> !b_drv);
   // R5
   ab_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (!ce_ab_n && !oe_ab_n) |-> b_drv);
   // R6
   ba_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (!ce_ba_n && !le_ba_n && !b_drv) |=> (a_out == $past(b_in)));
   // R6
   ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (le_ba_n || ce_ba_n) |=> $stable(a_out));
   // R7
   clash_chk: assert property (@(posedge clk) disable iff (rst)
      clash == (a_drv && b_drv));
   // R8
   ab_busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      a_drv |=> $stable(b_out));
   // R8
   ba_busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      b_drv |=> $stable(a_out));
endmodule

bind bxc_top bxc_top_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
   .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
   .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
   .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
   .clash(clash)
);

// File: tb/bxc_top_bench.sv
module bxc_top_bench;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] a_out;
      logic [W-1:0] b_out;
      logic         a_drv;
      logic         b_drv;
      logic         clash;
      string        tag;
   } exp_t;

   logic clk = 0;
   logic rst = 1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic ce_ab_n = 1, le_ab_n = 1, oe_ab_n = 1;
   logic ce_ba_n = 1, le_ba_n = 1, oe_ba_n = 1;
   logic [W-1:0] a_out, b_out;
   logic a_drv, b_drv, clash;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   exp_t q[$];
   event chk_ev;
   logic [W-1:0] m_ab = '0, m_ba = '0;

   always #5 clk = ~clk;

   bxc_top #(.WIDTH(W)) u_bxc_top (
      .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
      .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
      .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
      .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
      .clash(clash)
   );

   // monitor: pop and compare
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({a_out, b_out, a_drv, b_drv, clash} !==
                {e.a_out, e.b_out, e.a_drv, e.b_drv, e.clash}) begin
               errors++;
               $display("FAIL %s: actual a_out=%h b_out=%h a_drv=%b b_drv=%b clash=%b expected a_out=%h b_out=%h a_drv=%b b_drv=%b clash=%b",
                        e.tag, a_out, b_out, a_drv, b_drv, clash,
                        e.a_out, e.b_out, e.a_drv, e.b_drv, e.clash);
            end
         end
      end
   end

   // driver: apply at falling edge, model the rising edge, queue expectation
   task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ceab, input logic leab, input logic oeab,
                       input logic ceba, input logic leba, input logic oeba,
                       input string tag);
      logic pa, pb;
      exp_t e;
      @(negedge clk);
      rst = r; a_in = a; b_in = b;
      ce_ab_n = ceab; le_ab_n = leab; oe_ab_n = oeab;
      ce_ba_n = ceba; le_ba_n = leba; oe_ba_n = oeba;
      pb = !r && !ceab && !oeab;
      pa = !r && !ceba && !oeba;
      @(posedge clk);
      if (r) begin
         m_ab = '0; m_ba = '0;
      end else begin
         if (!ceab && !leab && !pa) m_ab = a;
         if (!ceba && !leba && !pb) m_ba = b;
      end
      e.a_out = m_ba; e.b_out = m_ab;
      e.a_drv = pa; e.b_drv = pb; e.clash = pa && pb;
      e.tag = tag;
      q.push_back(e);
      #2;
      -> chk_ev;
      #1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset with controls trying to drive and load
      step(1, 8'hFF, 8'hEE, 0, 0, 0, 1, 1, 1, "R1 reset clears, drivers off");
      step(1, 8'hAA, 8'hBB, 0, 0, 0, 0, 0, 0, "R1 reset holds all quiet");
      // R2 transparent A-to-B, R5 driver on
      step(0, 8'h5A, 8'h00, 0, 0, 0, 1, 1, 1, "R2 R5 open stage loads a_in");
      step(0, 8'hC3, 8'h00, 0, 0, 0, 1, 1, 1, "R2 open stage follows new a_in");
      // R3 release, R9 stored not live
      step(0, 8'h11, 8'h00, 0, 1, 0, 1, 1, 1, "R3 R9 latch released, keeps C3");
      step(0, 8'h3C, 8'h00, 0, 1, 0, 1, 1, 1, "R9 b_out ignores live a_in");
      // R5 output enable off
      step(0, 8'h3C, 8'h00, 0, 1, 1, 1, 1, 1, "R5 oe high drives nothing");
      // R4 chip enable high blocks load and drive
      step(0, 8'h22, 8'h00, 1, 0, 0, 1, 1, 1, "R4 ce high holds and no drive");
      // R6 B-to-A transparent with its driver
      step(0, 8'h22, 8'h96, 1, 1, 1, 0, 0, 0, "R6 B-to-A loads b_in and drives A");
      step(0, 8'h22, 8'h69, 1, 1, 1, 0, 1, 0, "R6 B-to-A hold after release");
      // R8 A-to-B open while A is driven: ignore a_in
      step(0, 8'h77, 8'h00, 0, 0, 1, 0, 1, 0, "R8 A-to-B ignores a_in while a_drv");
      // R7 clash both driving
      step(0, 8'h77, 8'h00, 0, 1, 0, 0, 1, 0, "R7 clash when both drive");
      // R8 B-to-A open while B driven: ignore b_in
      step(0, 8'h77, 8'h55, 0, 1, 0, 0, 0, 1, "R8 B-to-A ignores b_in while b_drv");
      // R6 ce_ba high: no drive
      step(0, 8'h77, 8'h55, 1, 1, 1, 1, 0, 0, "R6 ce_ba high no drive, hold");
      // both open, neither drives
      step(0, 8'hA5, 8'h5A, 0, 0, 1, 0, 0, 1, "R2 R6 both open both load");
      step(0, 8'h00, 8'hFF, 0, 0, 0, 0, 0, 1, "R2 load zero and drive B");
      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule